// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls a set of 8-bit general-purpose I/O ports behind a simple register bus. Each port has an output latch and a direction register with one bit per pin. From these it drives an output value and an output-enable for every pin. It also samples the pad inputs through a two-flop synchronizer. A read of a port's data register is assembled pin by pin. A pin set as an output returns its latch bit, and a pin set as an input returns its synchronized pad bit.

The first three ports also have pull-up requests. These come from a single 8-bit pull-up register. Its bits cover groups of pins of unequal size: nibbles, a pin pair and single pins. A pull-up request only reaches a pin while that pin is an input.

A control register holds an input-level select bit, which chooses CMOS or TTL thresholds. This bit resets to the level of a strap input. The register bus is a plain address/strobe interface with no flow control, so valid/ready back-pressure does not apply: every strobe is accepted in the cycle it is presented.

Top module: `gpio_ctrl`

## Requirements
- R1: Direction bit 1 makes the pin an output and raises `pad_oe_o` for that pin; direction bit 0 makes it an input with `pad_oe_o` low.
- R2: `pad_out_o` for a pin equals its output latch bit. A write to the data register of a port updates the latch even for input pins, and `pad_oe_o` stays low for those pins.
- R3: A read of port p's data register (address 2p) returns the latch bit for each pin whose direction bit is 1.
- R4: For pins whose direction bit is 0, the data read returns the pad value from two clock edges earlier (two-flop synchronizer).
- R5: Pull-up register (address 2·NUM_PORTS) bit mapping, with port.pin ranges: bit0→0.0–0.3, bit1→0.4–0.5, bit2→0.6, bit3→0.7, bit4→1.0–1.3, bit5→1.4–1.7, bit6→2.0–2.3, bit7→2.4–2.7. `pad_pull_o` is set only when the mapped bit is 1 and the pin's direction bit is 0.
- R6: Ports 3 and above never assert `pad_pull_o`.
- R7: Control register (address 2·NUM_PORTS+1) bit 7 is the input-level select: 0 means CMOS and 1 means TTL. It drives `ttl_sel_o`. During reset it loads `level_strap_i`.
- R8: Control register bits 6..0 read as 0, and writing them has no effect.
- R9: Reset clears all latches, direction bits, pull-up bits and synchronizer stages.
- R10: A write takes effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. Unmapped addresses read 0, and writes to them change nothing.
- R11: The direction register of port p (address 2p+1) and the pull-up register read back their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| level_strap_i | input | 1 | Reset value of the input-level select |
| pad_in_i | input | NUM_PORTS·8 | Pad input values (asynchronous) |
| pad_out_o | output | NUM_PORTS·8 | Per-pin output value |
| pad_oe_o | output | NUM_PORTS·8 | Per-pin output enable |
| pad_pull_o | output | NUM_PORTS·8 | Per-pin pull-up request |
| ttl_sel_o | output | 1 | Input-level select (1 = TTL) |

## Verification
The bench targets ports that have a mix of input and output pins. A design that muxes the data read per port rather than per pin would return the wrong source for half the bits. The bench changes pad values right before a read, so a synchronizer that is one stage short or one stage long shows up as a read that arrives a cycle early or late. It sets pull-up bits together with output directions: a mapping that is shifted by one group, or a pull-up that is not gated by direction, drives requests onto the wrong pins or onto driven pins. It also resets with the strap at both levels and writes to unused control bits and unmapped addresses. A hard-coded reset value, or a write path that is decoded too loosely, would then show up.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W     = 8;
  localparam int PULL_PORTS = 3;
  localparam int PULL_W     = 8;

  // pull-up register bit that serves a given pin; -1 when none
  function automatic int pull_bit_of(input int port, input int pin);
    int r;
    r = -1;
    case (port)
      0: begin
        if (pin < 4)       r = 0;
        else if (pin < 6)  r = 1;
        else if (pin == 6) r = 2;
        else               r = 3;
      end
      1: r = (pin < 4) ? 4 : 5;
      2: r = (pin < 4) ? 6 : 7;
      default: r = -1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // cycles since reset, saturating, for the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n) age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_o == $past(pad_i, 2)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_dat_i,
  input  logic              we_dir_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] pad_sync_i,
  output logic [PORT_W-1:0] out_o,
  output logic [PORT_W-1:0] oe_o,
  output logic [PORT_W-1:0] rd_dat_o
);
  logic [PORT_W-1:0] latch_q, dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (we_dat_i) latch_q <= wdata_i;
      if (we_dir_i) dir_q   <= wdata_i;
    end
  end

  // per-pin source select for data reads
  for (genvar b = 0; b < PORT_W; b++) begin : g_pin
    assign rd_dat_o[b] = dir_q[b] ? latch_q[b] : pad_sync_i[b];
  end

  assign out_o = latch_q;
  assign oe_o  = dir_q;

  a_r1_oe_after_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    we_dir_i |=> (oe_o == $past(wdata_i)));
  a_r2_latch_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    we_dat_i |=> (out_o == $past(wdata_i)));
  a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !we_dat_i |=> $stable(out_o));
endmodule

// File: rtl/gpio_pull.sv
module gpio_pull
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [PULL_W-1:0]           wdata_i,
  input  logic [NUM_PORTS*PORT_W-1:0] dir_i,
  output logic [NUM_PORTS*PORT_W-1:0] pull_o,
  output logic [PULL_W-1:0]           reg_o
);
  logic [PULL_W-1:0] pull_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pull_q <= '0;
    else if (we_i) pull_q <= wdata_i;
  end

  assign reg_o = pull_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar b = 0; b < PORT_W; b++) begin : g_pin
      localparam int SRC = pull_bit_of(p, b);
      if (p < PULL_PORTS && SRC >= 0) begin : g_has
        assign pull_o[p*PORT_W+b] = pull_q[SRC] & ~dir_i[p*PORT_W+b];
      end else begin : g_none
        assign pull_o[p*PORT_W+b] = 1'b0;
      end
    end
  end

  a_r5_no_pull_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_o & dir_i) == '0));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [7:0]                  bus_wdata,
  output logic [7:0]                  bus_rdata,
  input  logic                        level_strap_i,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in_i,
  output logic [NUM_PORTS*PORT_W-1:0] pad_out_o,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe_o,
  output logic [NUM_PORTS*PORT_W-1:0] pad_pull_o,
  output logic                        ttl_sel_o
);
  localparam int PINS      = NUM_PORTS * PORT_W;
  localparam int PULL_ADDR = 2 * NUM_PORTS;
  localparam int CTRL_ADDR = PULL_ADDR + 1;

  logic [PINS-1:0]      pad_sync;
  logic [NUM_PORTS-1:0] we_dat, we_dir;
  logic [PORT_W-1:0]    rd_dat [NUM_PORTS];
  logic [PULL_W-1:0]    pull_reg;
  logic                 lvl_q;
  logic                 we_pull, we_ctrl;

  gpio_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_in_i), .sync_o(pad_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign we_dat[p] = bus_we && (bus_addr == ADDR_W'(2*p));
    assign we_dir[p] = bus_we && (bus_addr == ADDR_W'(2*p+1));
    gpio_port u_port (
      .clk(clk), .rst_n(rst_n),
      .we_dat_i(we_dat[p]), .we_dir_i(we_dir[p]),
      .wdata_i(bus_wdata),
      .pad_sync_i(pad_sync[p*PORT_W +: PORT_W]),
      .out_o(pad_out_o[p*PORT_W +: PORT_W]),
      .oe_o(pad_oe_o[p*PORT_W +: PORT_W]),
      .rd_dat_o(rd_dat[p])
    );
  end

  assign we_pull = bus_we && (bus_addr == ADDR_W'(PULL_ADDR));
  assign we_ctrl = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));

  gpio_pull #(.NUM_PORTS(NUM_PORTS)) u_pull (
    .clk(clk), .rst_n(rst_n), .we_i(we_pull), .wdata_i(bus_wdata),
    .dir_i(pad_oe_o), .pull_o(pad_pull_o), .reg_o(pull_reg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       lvl_q <= level_strap_i;
    else if (we_ctrl) lvl_q <= bus_wdata[7];
  end
  assign ttl_sel_o = lvl_q;

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (bus_addr == ADDR_W'(2*p))   bus_rdata = rd_dat[p];
      if (bus_addr == ADDR_W'(2*p+1)) bus_rdata = pad_oe_o[p*PORT_W +: PORT_W];
    end
    if (bus_addr == ADDR_W'(PULL_ADDR)) bus_rdata = pull_reg;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata = {lvl_q, 7'b0};
  end

  a_r7_strap_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ttl_sel_o == $past(level_strap_i)));
  a_r8_ctrl_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CTRL_ADDR)) |-> (bus_rdata[6:0] == 7'd0));
endmodule

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;
  localparam int NP   = 4;
  localparam int AW   = 4;
  localparam int NPIN = NP * 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic            strap = 1'b1;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] pad_out, pad_oe, pad_pull;
  logic            ttl_sel;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  gpio_ctrl #(.NUM_PORTS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .level_strap_i(strap),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_pull_o(pad_pull), .ttl_sel_o(ttl_sel)
  );

  // reference model state
  logic [7:0]      m_lat [NP];
  logic [7:0]      m_dir [NP];
  logic [7:0]      m_pull;
  logic            m_lvl;
  logic [NPIN-1:0] m_s1, m_s2;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin m_lat[i] = 0; m_dir[i] = 0; end
      m_pull = 0; m_lvl = strap; m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2 = m_s1; m_s1 = pad_in;
      if (bus_we) begin
        if (int'(bus_addr) < 2*NP) begin
          if (bus_addr[0]) m_dir[bus_addr/2] = bus_wdata;
          else             m_lat[bus_addr/2] = bus_wdata;
        end else if (int'(bus_addr) == 2*NP)   m_pull = bus_wdata;
        else if (int'(bus_addr) == 2*NP+1)     m_lvl  = bus_wdata[7];
      end
    end
  end

  function automatic int grp(input int pin);
    int port, b;
    port = pin / 8; b = pin % 8;
    if (port == 0) return (b <= 3) ? 0 : (b <= 5) ? 1 : (b == 6) ? 2 : 3;
    if (port == 1) return (b <= 3) ? 4 : 5;
    if (port == 2) return (b <= 3) ? 6 : 7;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [NPIN-1:0] e_out, e_oe, e_pull;
    logic [7:0] e_rd;
    int a;
    if (m_lvl !== 1'bx) begin
      for (int p = 0; p < NP; p++) begin
        e_out[p*8 +: 8] = m_lat[p];
        e_oe[p*8 +: 8]  = m_dir[p];
      end
      for (int i = 0; i < NPIN; i++)
        e_pull[i] = (grp(i) >= 0) ? (m_pull[grp(i)] & ~e_oe[i]) : 1'b0;
      chk("R1 oe", pad_oe, e_oe);
      chk("R2 out", pad_out, e_out);
      chk("R5 pull", pad_pull[23:0], e_pull[23:0]);
      chk("R6 pull", pad_pull[NPIN-1:24], e_pull[NPIN-1:24]);
      chk("R7 ttl", ttl_sel, m_lvl);
      a = int'(bus_addr);
      if (a < 2*NP) begin
        if (a % 2 == 0) begin
          for (int b = 0; b < 8; b++)
            e_rd[b] = m_dir[a/2][b] ? m_lat[a/2][b] : m_s2[(a/2)*8+b];
          chk("R3/R4 data read", bus_rdata, e_rd);
        end else chk("R11 dir read", bus_rdata, m_dir[a/2]);
      end else if (a == 2*NP)   chk("R11 pull read", bus_rdata, m_pull);
      else if (a == 2*NP+1)     chk("R8 ctrl read", bus_rdata, {m_lvl, 7'b0});
      else                      chk("R10 unmapped read", bus_rdata, 8'h00);
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); #1;
    bus_addr = AW'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk); #1;
    bus_addr = AW'(a); bus_we = 1'b0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); #1;
    rst_n = 1'b0; strap = s; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    // R9: everything cleared after reset
    @(negedge clk);
    chk("R9 reset oe", pad_oe, '0);
    chk("R9 reset out", pad_out, '0);
    chk("R9 reset pull", pad_pull, '0);
    chk("R7 strap high", ttl_sel, 1'b1);
    // R2: latch write on input pins keeps oe low
    wr(0, 8'hA5);
    rd(0);
    chk("R2 latch on input", pad_out[7:0], 8'hA5);
    chk("R2 oe low", pad_oe[7:0], 8'h00);
    // mixed port: R3 latch / R4 pad
    wr(1, 8'h0F);
    pad_in[7:0] = 8'h3C;
    rd(0);
    repeat (3) @(negedge clk);
    chk("R3/R4 mixed read", bus_rdata, 8'h35);
    // R5 pull groups with direction gating
    wr(2*NP, 8'hFF);
    chk("R5 pull gated", pad_pull[7:0], 8'hF0);
    chk("R6 upper port", pad_pull[31:24], 8'h00);
    wr(2*NP, 8'b0000_0110);
    chk("R5 group map", pad_pull[7:0], 8'h70);
    // R8 write of ctrl low bits ignored, bit7 updates
    wr(2*NP+1, 8'h7F);
    rd(2*NP+1);
    #1 chk("R8 ctrl low bits", bus_rdata, 8'h00);
    chk("R7 ttl written", ttl_sel, 1'b0);
    // R10 unmapped write changes nothing
    wr(15, 8'hFF);
    rd(15);
    #1 chk("R10 unmapped", bus_rdata, 8'h00);
    // random traffic with pad activity
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #1;
      bus_addr = AW'($urandom_range(0, 15));
      bus_we = ($urandom_range(0, 2) == 0);
      bus_wdata = 8'($urandom);
      if ($urandom_range(0, 3) == 0) pad_in = NPIN'($urandom);
      if (k == 1500) begin
        bus_we = 1'b0;
        do_reset(1'b0);
        @(negedge clk);
        chk("R7 strap low", ttl_sel, 1'b0);
      end
    end
    @(negedge clk); #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule